// File: doc/BRIEF.md
# ECC Error Status Capture

This block sits between a memory controller that performs error correction and the per-bank status registers that software reads. The controller reports two classes of error on two independent report channels: single-bit errors that were corrected, and double-bit errors that could only be detected. Each report names a bank and carries the failing address, the syndrome, the transfer ID and the transfer type. The block keeps, for every bank and for each class on its own, a status flag, a sticky overflow flag and the details of the first error of that class.

Any set flag of the corrected class holds the interrupt output high. Any set flag of the detected class holds the exception output high. Software reads the captured values through a read port addressed by bank and field index. It clears flags one at a time by naming a bank and a bit index. Because the two classes have separate capture paths, errors that arrive on back-to-back cycles, or two classes that arrive on the same cycle, are each recorded on their own.

Top module: `ecc_err_capture`

## Requirements
- R1: A corrected-error report to bank b (`corr_valid` high) sets bank b's corrected flag (status bit 0) on the next clock edge, and `irq_corr` is high from then on.
- R2: A detected-error report to bank b (`det_valid` high) sets bank b's detected flag (status bit 1) on the next clock edge, and `exc_det` is high from then on.
- R3: A report whose class flag is clear loads address, syndrome, ID and type into that bank's fields for that class. Read field indices are: 0 status, 1 corrected address, 2 corrected syndrome, 3 corrected ID, 4 corrected type, 5 detected address, 6 detected syndrome, 7 detected ID, 8 detected type. Values are zero-extended to the read width, and indices 9 to 15 read zero.
- R4: A report that arrives while that class's flag is already set, and is not being cleared in the same cycle, leaves the stored details unchanged. It sets the class overflow bit, which is status bit 2 for the corrected class and bit 3 for the detected class.
- R5: Reports of one class on consecutive cycles to different banks are both captured with their own details.
- R6: A corrected and a detected report on the same cycle, even to the same bank, are both captured independently.
- R7: A clear operation (`clr_valid` high) clears only the status bit selected by `clr_bank` and `clr_bit` (0 to 3, as in R1, R2 and R4). All other bits keep their values.
- R8: When a report and a clear of the same class flag fall on the same cycle, the flag stays set, the new details are loaded, and the overflow bit is unchanged.
- R9: `irq_corr` stays high while any bank has status bit 0 or 2 set. `exc_det` stays high while any bank has status bit 1 or 3 set. Each output drops one edge after the last such bit is cleared.
- R10: After reset every status bit and every field reads zero, and both outputs are low.
- R11: Clearing a status bit that is already clear has no effect on any status bit or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| corr_valid | input | 1 | Corrected-error report strobe |
| corr_bank | input | BANK_W | Bank of the corrected report |
| corr_addr | input | ADDR_W | Failing address |
| corr_syn | input | SYN_W | Syndrome |
| corr_id | input | ID_W | Transfer ID |
| corr_kind | input | KIND_W | Transfer type |
| det_valid | input | 1 | Detected-error report strobe |
| det_bank | input | BANK_W | Bank of the detected report |
| det_addr | input | ADDR_W | Failing address |
| det_syn | input | SYN_W | Syndrome |
| det_id | input | ID_W | Transfer ID |
| det_kind | input | KIND_W | Transfer type |
| clr_valid | input | 1 | Clear one status bit |
| clr_bank | input | BANK_W | Bank to clear in |
| clr_bit | input | 2 | Status bit index to clear |
| rd_bank | input | BANK_W | Read bank select |
| rd_field | input | 4 | Read field index |
| rd_data | output | DATA_W | Selected field, zero-extended |
| irq_corr | output | 1 | Corrected-error interrupt |
| exc_det | output | 1 | Detected-error exception |

## Verification
Each report is sampled on a rising edge, and its flag and fields are visible on the port after that same edge. The interrupt and exception come straight from the flag registers, so they change with the same edge as the flag that drives them. With the default combinational read path, `rd_data` follows `rd_bank` and `rd_field` within the cycle. The bench drives every input on the falling edge and lets exactly one rising edge pass. It then reads status, fields and outputs on the next falling edge, a short settle after setting the read address. Races are built by placing a report and a clear in the same driven cycle, and back-to-back cases by changing the report on the following falling edge without dropping valid.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

   // status bit positions inside a bank's status word
   localparam int unsigned ST_CORR     = 0;
   localparam int unsigned ST_DET      = 1;
   localparam int unsigned ST_CORR_OVF = 2;
   localparam int unsigned ST_DET_OVF  = 3;
   localparam int unsigned ST_W        = 4;

   // error classes, one capture path each
   localparam int unsigned CLS_CORR = 0;
   localparam int unsigned CLS_DET  = 1;
   localparam int unsigned NUM_CLS  = 2;

   typedef enum logic [3:0] {
      FLD_STATUS    = 4'd0,
      FLD_CORR_ADDR = 4'd1,
      FLD_CORR_SYN  = 4'd2,
      FLD_CORR_ID   = 4'd3,
      FLD_CORR_KIND = 4'd4,
      FLD_DET_ADDR  = 4'd5,
      FLD_DET_SYN   = 4'd6,
      FLD_DET_ID    = 4'd7,
      FLD_DET_KIND  = 4'd8
   } field_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ecc_class_slot.sv
// One bank, one error class: flag, sticky overflow and first-error details.
module ecc_class_slot #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SYN_W  = 8,
   parameter int unsigned ID_W   = 6,
   parameter int unsigned KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [SYN_W-1:0]  in_syn,
   input  logic [ID_W-1:0]   in_id,
   input  logic [KIND_W-1:0] in_kind,
   input  logic              clr_flag,
   input  logic              clr_ovf,
   output logic              flag,
   output logic              ovf,
   output logic [ADDR_W-1:0] q_addr,
   output logic [SYN_W-1:0]  q_syn,
   output logic [ID_W-1:0]   q_id,
   output logic [KIND_W-1:0] q_kind
);

   logic occupied;
   logic load;

   // a flag being cleared this cycle frees the slot for the new report
   assign occupied = flag & ~clr_flag;
   assign load     = hit & ~occupied;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;
      end else if (clr_flag) begin
         flag <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (hit && occupied) begin
         ovf <= 1'b1;
      end else if (clr_ovf) begin
         ovf <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_addr <= '0;
         q_syn  <= '0;
         q_id   <= '0;
         q_kind <= '0;
      end else if (load) begin
         q_addr <= in_addr;
         q_syn  <= in_syn;
         q_id   <= in_id;
         q_kind <= in_kind;
      end
   end

   assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   assert_keep_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_flag) |=> (q_addr == $past(q_addr) && q_syn == $past(q_syn)));

   assert_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && flag && !clr_flag) |=> ovf);

   assert_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && flag && clr_flag) |=> (flag && q_addr == $past(in_addr) && ovf == $past(ovf)));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flag && !hit) |=> !flag);

endmodule

// File: rtl/ecc_read_mux.sv
// Selects one captured field of one bank; RD_REG picks a combinational or registered path.
module ecc_read_mux
   import ecc_err_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SYN_W     = 8,
   parameter int unsigned ID_W      = 6,
   parameter int unsigned KIND_W    = 2,
   parameter int unsigned DATA_W    = 16,
   parameter bit          RD_REG    = 1'b0,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic [BANK_W-1:0]                            rd_bank,
   input  logic [3:0]                                   rd_field,
   input  logic [NUM_BANKS-1:0][ST_W-1:0]               status,
   input  logic [NUM_CLS-1:0][NUM_BANKS-1:0][ADDR_W-1:0] f_addr,
   input  logic [NUM_CLS-1:0][NUM_BANKS-1:0][SYN_W-1:0]  f_syn,
   input  logic [NUM_CLS-1:0][NUM_BANKS-1:0][ID_W-1:0]   f_id,
   input  logic [NUM_CLS-1:0][NUM_BANKS-1:0][KIND_W-1:0] f_kind,
   output logic [DATA_W-1:0]                            rd_data
);

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      case (rd_field)
         FLD_STATUS:    sel = DATA_W'(status[rd_bank]);
         FLD_CORR_ADDR: sel = DATA_W'(f_addr[CLS_CORR][rd_bank]);
         FLD_CORR_SYN:  sel = DATA_W'(f_syn[CLS_CORR][rd_bank]);
         FLD_CORR_ID:   sel = DATA_W'(f_id[CLS_CORR][rd_bank]);
         FLD_CORR_KIND: sel = DATA_W'(f_kind[CLS_CORR][rd_bank]);
         FLD_DET_ADDR:  sel = DATA_W'(f_addr[CLS_DET][rd_bank]);
         FLD_DET_SYN:   sel = DATA_W'(f_syn[CLS_DET][rd_bank]);
         FLD_DET_ID:    sel = DATA_W'(f_id[CLS_DET][rd_bank]);
         FLD_DET_KIND:  sel = DATA_W'(f_kind[CLS_DET][rd_bank]);
         default:       sel = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= sel;
         end
      end else begin : g_rd_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rd_data    = sel;
      end
   endgenerate

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecc_err_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SYN_W     = 8,
   parameter int unsigned ID_W      = 6,
   parameter int unsigned KIND_W    = 2,
   parameter bit          RD_REG    = 1'b0,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
   localparam int unsigned DATA_W   = max_of(max_of(ADDR_W, SYN_W),
                                             max_of(max_of(ID_W, KIND_W), ST_W))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              corr_valid,
   input  logic [BANK_W-1:0] corr_bank,
   input  logic [ADDR_W-1:0] corr_addr,
   input  logic [SYN_W-1:0]  corr_syn,
   input  logic [ID_W-1:0]   corr_id,
   input  logic [KIND_W-1:0] corr_kind,
   input  logic              det_valid,
   input  logic [BANK_W-1:0] det_bank,
   input  logic [ADDR_W-1:0] det_addr,
   input  logic [SYN_W-1:0]  det_syn,
   input  logic [ID_W-1:0]   det_id,
   input  logic [KIND_W-1:0] det_kind,
   input  logic              clr_valid,
   input  logic [BANK_W-1:0] clr_bank,
   input  logic [1:0]        clr_bit,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [3:0]        rd_field,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_corr,
   output logic              exc_det
);

   initial begin
      assert (NUM_BANKS >= 2 && (1 << BANK_W) == NUM_BANKS)
         else $error("NUM_BANKS must be a power of two, at least 2");
      assert (ADDR_W >= 1 && SYN_W >= 1 && ID_W >= 1 && KIND_W >= 1)
         else $error("field widths must be at least 1");
   end

   // per-class view of the two report channels
   logic [NUM_CLS-1:0]             c_valid;
   logic [NUM_CLS-1:0][BANK_W-1:0] c_bank;
   logic [NUM_CLS-1:0][ADDR_W-1:0] c_addr;
   logic [NUM_CLS-1:0][SYN_W-1:0]  c_syn;
   logic [NUM_CLS-1:0][ID_W-1:0]   c_id;
   logic [NUM_CLS-1:0][KIND_W-1:0] c_kind;

   assign c_valid[CLS_CORR] = corr_valid;
   assign c_bank[CLS_CORR]  = corr_bank;
   assign c_addr[CLS_CORR]  = corr_addr;
   assign c_syn[CLS_CORR]   = corr_syn;
   assign c_id[CLS_CORR]    = corr_id;
   assign c_kind[CLS_CORR]  = corr_kind;
   assign c_valid[CLS_DET]  = det_valid;
   assign c_bank[CLS_DET]   = det_bank;
   assign c_addr[CLS_DET]   = det_addr;
   assign c_syn[CLS_DET]    = det_syn;
   assign c_id[CLS_DET]     = det_id;
   assign c_kind[CLS_DET]   = det_kind;

   logic [NUM_CLS-1:0][NUM_BANKS-1:0]             flag;
   logic [NUM_CLS-1:0][NUM_BANKS-1:0]             ovf;
   logic [NUM_CLS-1:0][NUM_BANKS-1:0][ADDR_W-1:0] f_addr;
   logic [NUM_CLS-1:0][NUM_BANKS-1:0][SYN_W-1:0]  f_syn;
   logic [NUM_CLS-1:0][NUM_BANKS-1:0][ID_W-1:0]   f_id;
   logic [NUM_CLS-1:0][NUM_BANKS-1:0][KIND_W-1:0] f_kind;
   logic [NUM_BANKS-1:0][ST_W-1:0]                status;

   // one decoded clear strobe per bank and status bit
   logic [NUM_BANKS-1:0][ST_W-1:0] clr_dec;

   genvar gb, gc;
   generate
      for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
         always_comb begin
            clr_dec[gb] = '0;
            if (clr_valid && clr_bank == BANK_W'(gb)) clr_dec[gb][clr_bit] = 1'b1;
         end

         assign status[gb][ST_CORR]     = flag[CLS_CORR][gb];
         assign status[gb][ST_DET]      = flag[CLS_DET][gb];
         assign status[gb][ST_CORR_OVF] = ovf[CLS_CORR][gb];
         assign status[gb][ST_DET_OVF]  = ovf[CLS_DET][gb];

         for (gc = 0; gc < NUM_CLS; gc++) begin : g_cls
            localparam int unsigned FLAG_BIT = (gc == CLS_CORR) ? ST_CORR : ST_DET;
            localparam int unsigned OVF_BIT  = (gc == CLS_CORR) ? ST_CORR_OVF : ST_DET_OVF;
            logic hit;
            assign hit = c_valid[gc] && (c_bank[gc] == BANK_W'(gb));

            ecc_class_slot #(
               .ADDR_W (ADDR_W),
               .SYN_W  (SYN_W),
               .ID_W   (ID_W),
               .KIND_W (KIND_W)
            ) u_slot (
               .clk      (clk),
               .rst_n    (rst_n),
               .hit      (hit),
               .in_addr  (c_addr[gc]),
               .in_syn   (c_syn[gc]),
               .in_id    (c_id[gc]),
               .in_kind  (c_kind[gc]),
               .clr_flag (clr_dec[gb][FLAG_BIT]),
               .clr_ovf  (clr_dec[gb][OVF_BIT]),
               .flag     (flag[gc][gb]),
               .ovf      (ovf[gc][gb]),
               .q_addr   (f_addr[gc][gb]),
               .q_syn    (f_syn[gc][gb]),
               .q_id     (f_id[gc][gb]),
               .q_kind   (f_kind[gc][gb])
            );
         end

         assert_clear_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_valid && clr_bank == BANK_W'(gb) && !corr_valid && !det_valid)
               |=> ((status[gb] | ((ST_W)'(1) << $past(clr_bit))) ==
                    ($past(status[gb]) | ((ST_W)'(1) << $past(clr_bit)))));
      end
   endgenerate

   assign irq_corr = |(flag[CLS_CORR] | ovf[CLS_CORR]);
   assign exc_det  = |(flag[CLS_DET]  | ovf[CLS_DET]);

   ecc_read_mux #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .SYN_W     (SYN_W),
      .ID_W      (ID_W),
      .KIND_W    (KIND_W),
      .DATA_W    (DATA_W),
      .RD_REG    (RD_REG)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_bank  (rd_bank),
      .rd_field (rd_field),
      .status   (status),
      .f_addr   (f_addr),
      .f_syn    (f_syn),
      .f_id     (f_id),
      .f_kind   (f_kind),
      .rd_data  (rd_data)
   );

   assert_irq_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_corr) |-> $past(corr_valid));

   assert_exc_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exc_det) |-> $past(det_valid));

   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!corr_valid && !clr_valid) |=> $stable(irq_corr));

   assert_exc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_valid && !clr_valid) |=> $stable(exc_det));

endmodule

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;

   localparam int unsigned NB = 4;
   localparam int unsigned BW = 2;
   localparam int unsigned DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          corr_valid = 1'b0, det_valid = 1'b0, clr_valid = 1'b0;
   logic [BW-1:0] corr_bank = '0, det_bank = '0, clr_bank = '0, rd_bank = '0;
   logic [15:0]   corr_addr = '0, det_addr = '0;
   logic [7:0]    corr_syn = '0, det_syn = '0;
   logic [5:0]    corr_id = '0, det_id = '0;
   logic [1:0]    corr_kind = '0, det_kind = '0, clr_bit = '0;
   logic [3:0]    rd_field = '0;
   logic [DW-1:0] rd_data;
   logic          irq_corr, exc_det;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ecc_err_capture u_ecc_err_capture (
      .clk(clk), .rst_n(rst_n),
      .corr_valid(corr_valid), .corr_bank(corr_bank), .corr_addr(corr_addr),
      .corr_syn(corr_syn), .corr_id(corr_id), .corr_kind(corr_kind),
      .det_valid(det_valid), .det_bank(det_bank), .det_addr(det_addr),
      .det_syn(det_syn), .det_id(det_id), .det_kind(det_kind),
      .clr_valid(clr_valid), .clr_bank(clr_bank), .clr_bit(clr_bit),
      .rd_bank(rd_bank), .rd_field(rd_field), .rd_data(rd_data),
      .irq_corr(irq_corr), .exc_det(exc_det)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input int b, input int f, output logic [DW-1:0] v);
      rd_bank  = BW'(b);
      rd_field = 4'(f);
      #0.5;
      v = rd_data;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put_corr(input int b, input logic [15:0] a, input logic [7:0] s,
                           input logic [5:0] i, input logic [1:0] k);
      corr_valid = 1'b1; corr_bank = BW'(b); corr_addr = a;
      corr_syn = s; corr_id = i; corr_kind = k;
   endtask

   task automatic put_det(input int b, input logic [15:0] a, input logic [7:0] s,
                          input logic [5:0] i, input logic [1:0] k);
      det_valid = 1'b1; det_bank = BW'(b); det_addr = a;
      det_syn = s; det_id = i; det_kind = k;
   endtask

   task automatic put_clr(input int b, input int bitidx);
      clr_valid = 1'b1; clr_bank = BW'(b); clr_bit = 2'(bitidx);
   endtask

   task automatic idle();
      corr_valid = 1'b0; det_valid = 1'b0; clr_valid = 1'b0;
   endtask

   task automatic wipe_all();
      for (int b = 0; b < NB; b++) begin
         for (int k = 0; k < 4; k++) begin
            put_clr(b, k);
            tick();
         end
      end
      idle();
      tick();
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      check("R10 irq after reset", 32'(irq_corr), 0);
      check("R10 exc after reset", 32'(exc_det), 0);
      for (int b = 0; b < NB; b++) begin
         rd(b, 0, v); check("R10 status zero", 32'(v), 0);
         rd(b, 1, v); check("R10 field zero", 32'(v), 0);
      end
   endtask

   task automatic t_corr_basic();
      logic [DW-1:0] v;
      put_corr(1, 16'h1234, 8'h5A, 6'd3, 2'd1);
      tick(); idle();
      rd(1, 0, v); check("R1 status corr flag", 32'(v), 32'h1);
      check("R1 irq high", 32'(irq_corr), 1);
      check("R2 exc stays low", 32'(exc_det), 0);
      rd(1, 1, v); check("R3 corr addr", 32'(v), 32'h1234);
      rd(1, 2, v); check("R3 corr syn", 32'(v), 32'h5A);
      rd(1, 3, v); check("R3 corr id", 32'(v), 3);
      rd(1, 4, v); check("R3 corr kind", 32'(v), 1);
      rd(1, 12, v); check("R3 unused index", 32'(v), 0);
      // clear a bit that is not set
      put_clr(1, 1); tick(); idle();
      rd(1, 0, v); check("R11 clear of empty bit", 32'(v), 32'h1);
      check("R11 irq unchanged", 32'(irq_corr), 1);
      put_clr(1, 0); tick(); idle();
      rd(1, 0, v); check("R7 flag cleared", 32'(v), 0);
      check("R9 irq drops", 32'(irq_corr), 0);
   endtask

   task automatic t_det_basic();
      logic [DW-1:0] v;
      put_det(2, 16'hBEEF, 8'hC3, 6'd17, 2'd2);
      tick(); idle();
      rd(2, 0, v); check("R2 status det flag", 32'(v), 32'h2);
      check("R2 exc high", 32'(exc_det), 1);
      check("R1 irq stays low", 32'(irq_corr), 0);
      rd(2, 5, v); check("R3 det addr", 32'(v), 32'hBEEF);
      rd(2, 6, v); check("R3 det syn", 32'(v), 32'hC3);
      rd(2, 7, v); check("R3 det id", 32'(v), 17);
      rd(2, 8, v); check("R3 det kind", 32'(v), 2);
      wipe_all();
      check("R9 exc drops", 32'(exc_det), 0);
   endtask

   task automatic t_back_to_back();
      logic [DW-1:0] v;
      put_corr(0, 16'h0A0A, 8'h11, 6'd1, 2'd0);
      tick();
      put_corr(3, 16'h0B0B, 8'h22, 6'd2, 2'd3);
      tick(); idle();
      rd(0, 1, v); check("R5 first bank addr", 32'(v), 32'h0A0A);
      rd(3, 1, v); check("R5 second bank addr", 32'(v), 32'h0B0B);
      rd(3, 4, v); check("R5 second bank kind", 32'(v), 3);
      rd(0, 0, v); check("R5 first bank status", 32'(v), 32'h1);
      // same bank again while set
      put_corr(0, 16'h0C0C, 8'h33, 6'd5, 2'd1);
      tick(); idle();
      rd(0, 0, v); check("R4 overflow bit", 32'(v), 32'h5);
      rd(0, 1, v); check("R4 addr kept", 32'(v), 32'h0A0A);
      rd(0, 2, v); check("R4 syn kept", 32'(v), 32'h11);
   endtask

   task automatic t_race();
      logic [DW-1:0] v;
      // bank0 holds corr flag + overflow from previous scenario
      put_clr(0, 0);
      put_corr(0, 16'h7777, 8'h44, 6'd9, 2'd2);
      tick(); idle();
      rd(0, 0, v); check("R8 flag kept, ovf unchanged", 32'(v), 32'h5);
      rd(0, 1, v); check("R8 new addr loaded", 32'(v), 32'h7777);
      rd(0, 3, v); check("R8 new id loaded", 32'(v), 9);
   endtask

   task automatic t_irq_hold();
      logic [DW-1:0] v;
      // set: bank0 bits 0 and 2, bank3 bit 0
      put_clr(0, 2); tick(); idle();
      check("R9 irq held by other bits", 32'(irq_corr), 1);
      put_clr(0, 0); tick(); idle();
      check("R9 irq held by bank3", 32'(irq_corr), 1);
      rd(3, 0, v); check("R7 bank3 untouched", 32'(v), 32'h1);
      put_clr(3, 0); tick(); idle();
      check("R9 irq drops after last", 32'(irq_corr), 0);
   endtask

   task automatic t_same_cycle();
      logic [DW-1:0] v;
      put_corr(2, 16'h1111, 8'h01, 6'd4, 2'd1);
      put_det(2, 16'h2222, 8'h02, 6'd8, 2'd2);
      tick(); idle();
      rd(2, 0, v); check("R6 both flags", 32'(v), 32'h3);
      rd(2, 1, v); check("R6 corr addr", 32'(v), 32'h1111);
      rd(2, 5, v); check("R6 det addr", 32'(v), 32'h2222);
      rd(2, 7, v); check("R6 det id", 32'(v), 8);
      check("R6 irq", 32'(irq_corr), 1);
      check("R6 exc", 32'(exc_det), 1);
      put_clr(2, 1); tick(); idle();
      rd(2, 0, v); check("R7 only det cleared", 32'(v), 32'h1);
      check("R9 exc low, irq high", 32'({exc_det, irq_corr}), 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_corr_basic();
      t_det_basic();
      t_back_to_back();
      t_race();
      t_irq_hold();
      t_same_cycle();
      wipe_all();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule